// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog that software must service inside a programmable time window. A count-enable strobe, standing in for a slow oscillator, is divided by a selectable prescaler to form the count tick. A selectable timeout sets the reload value of the down-counter. The counter stays idle after reset until software writes the first valid service pair to the refresh register. From then on it decrements once per tick.

Servicing is a two-write unlock: 0x00 and then 0xFF to the refresh register. The pair is accepted only if the counter value at the time of the 0xFF write lies inside a window. The window's upper and lower bounds are set as fractions of the period. An accepted pair reloads the counter a fixed number of ticks later. Three events each set their own sticky status flag: a pair completed outside the window, a stray 0xFF, and counter underflow. A mode bit in the response register routes any set flag either to an interrupt output or to a reset output.

Top module: `winwdt_top`

## Requirements
- R1: After reset, irqOut and rstOut are low, and the status register reads 0. The control register (address 0x2) reads 0x3303, and the response register (address 0x6) reads 0.
- R2: While no valid pair has been accepted since reset, the counter does not run and no underflow is flagged, however long the count-enable strobe is active.
- R3: The timeout field is control bits [1:0], with codes 00/01/10/11 giving periods N of 1024/4096/8192/16384 ticks. The counter starts at N-1 on the valid pair that starts it, and underflow flag (status bit 0) is set on the N-th tick after the edge that sampled the 0xFF.
- R4: The prescaler field is control bits [7:4]. Codes 0..8 give one tick per 1, 4, 16, 32, 64, 256, 512, 2048 and 8192 count-enable pulses, and any other code gives one tick per pulse. The prescaler restarts from zero when the counter starts, and cycles with count-enable low do not advance it.
- R5: Window upper bound code W = control bits [13:12] gives 25/50/75/100 % (codes 00/01/10/11). Window lower bound code E = control bits [9:8] gives 75/50/25/0 % (codes 00/01/10/11). With q = N/4, a pair is in the window when the counter value c at the 0xFF write satisfies q*(3-E) <= c <= q*(W+1)-1.
- R6: An in-window pair on a running counter reloads it to N-1 on the second tick after the 0xFF write. The counter keeps decrementing until that tick.
- R7: A pair completed outside the window on a running counter sets status bit 2 and does not reload the counter.
- R8: A 0xFF write to the refresh register (address 0x0) whose previous refresh-register write was not 0x00 sets status bit 1, and neither starts nor reloads the counter.
- R9: On underflow, status bit 0 is set, the counter reloads to N-1 and continues counting, so underflows repeat every N ticks.
- R10: A write to the status register (address 0x4) clears every flag whose written data bit is 0. A flag event in the same cycle takes precedence over the clear.
- R11: Response register bit 7 set to 1 makes irqOut equal to the OR of the flags. Set to 0, it makes rstOut equal to that OR. The two outputs are never high together.
- R12: Control writes keep only bits 0x33F3 (other bits read 0) and are ignored once the counter has started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for bus and counting |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count-enable strobe, one oscillator pulse per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write byte address (0x0, 0x2, 0x4, 0x6) |
| wrData | input | 16 | Write data; byte registers use bits [7:0] |
| rdAddr | input | 3 | Read byte address |
| rdData | output | 16 | Combinational read data; refresh register reads 0 |
| irqOut | output | 1 | Interrupt response to any set flag |
| rstOut | output | 1 | Reset response to any set flag |

## Verification
The assertions assume that each write is a single-cycle strobe with an even address and that count-enable is a per-cycle qualifier rather than a clock. They also assume that reset is the only way to return the block to its idle state. The stimulus therefore changes inputs only between clock edges and holds each write for exactly one edge. In the random phase it limits timeout and prescaler codes to small values, so that underflows, window hits and window misses all occur many times within a short run.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  localparam int CNT_W  = 14;
  localparam int PRE_W  = 13;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int FLAG_W = 3;

  localparam logic [ADDR_W-1:0] ADR_REFRESH = 3'h0;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'h2;
  localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'h4;
  localparam logic [ADDR_W-1:0] ADR_RSTCTL  = 3'h6;

  localparam logic [DATA_W-1:0] CTRL_MASK  = 16'h33F3;
  localparam logic [DATA_W-1:0] CTRL_RESET = 16'h3303;

  // flag positions in the status register
  localparam int FLG_UNDER = 0;
  localparam int FLG_SEQ   = 1;
  localparam int FLG_WIN   = 2;

  typedef struct packed {
    logic [1:0] winStart;
    logic [1:0] winEnd;
    logic [3:0] preSel;
    logic [1:0] period;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startCnt;
    logic reloadReq;
  } dpCmd_t;

  function automatic logic [CNT_W-1:0] reloadOf(input logic [1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      2'd0:    r = CNT_W'(1023);
      2'd1:    r = CNT_W'(4095);
      2'd2:    r = CNT_W'(8191);
      default: r = CNT_W'(16383);
    endcase
    return r;
  endfunction

  function automatic logic [3:0] shiftOf(input logic [3:0] sel);
    logic [3:0] s;
    case (sel)
      4'd1:    s = 4'd2;
      4'd2:    s = 4'd4;
      4'd3:    s = 4'd5;
      4'd4:    s = 4'd6;
      4'd5:    s = 4'd8;
      4'd6:    s = 4'd9;
      4'd7:    s = 4'd11;
      4'd8:    s = 4'd13;
      default: s = 4'd0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/winwdt_dp.sv
module winwdt_dp
  import winwdt_pkg::*;
#(
  parameter int RELOAD_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             run,
  input  dpCmd_t           cmd,
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] cntVal,
  output logic             tickStb,
  output logic             underflow
);
  localparam int LAT_W = (RELOAD_LAT > 1) ? $clog2(RELOAD_LAT) : 1;
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(RELOAD_LAT - 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic [CNT_W-1:0] reloadVal;
  logic             pendQ;
  logic [LAT_W-1:0] pendCnt;
  logic             loadNow;

  always_comb begin
    reloadVal = reloadOf(cfg.period);
    preMask   = PRE_W'((32'd1 << shiftOf(cfg.preSel)) - 32'd1);
    tickStb   = run && cntEn && ((preCnt & preMask) == preMask);
    loadNow   = tickStb && pendQ && (pendCnt == LAT_LAST);
    underflow = tickStb && !loadNow && (cntVal == '0);
  end

  // prescaler: counts enable pulses, restarts with the counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (cmd.startCnt)    preCnt <= '0;
    else if (run && cntEn)    preCnt <= preCnt + 1'b1;
  end

  // pending reload after an accepted service pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pendQ <= 1'b0;
    else if (cmd.reloadReq) pendQ <= 1'b1;
    else if (loadNow)       pendQ <= 1'b0;
  end

  generate
    if (RELOAD_LAT > 1) begin : g_latCnt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                              pendCnt <= '0;
        else if (cmd.reloadReq)                 pendCnt <= '0;
        else if (tickStb && pendQ && !loadNow)  pendCnt <= pendCnt + 1'b1;
      end
    end else begin : g_latNone
      assign pendCnt = '0;
    end
  endgenerate

  // down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cntVal <= reloadOf(CTRL_RESET[1:0]);
    else if (!run)                  cntVal <= reloadVal;
    else if (loadNow || underflow)  cntVal <= reloadVal;
    else if (tickStb)               cntVal <= cntVal - 1'b1;
  end
endmodule

// File: rtl/winwdt_ctrl.sv
module winwdt_ctrl
  import winwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              underflow,
  output dpCmd_t            cmd,
  output cfg_t              cfg,
  output logic              runQ,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [FLAG_W-1:0] flags,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstOut
);
  localparam int Q_W = CNT_W + 1;

  logic          armQ;
  logic          irqSelQ;
  logic          refWr, wrZero, wrAll, goodSeq, badSeq, inWin, winErr;
  logic [Q_W-1:0] quarter, hiMul, loMul, winHi, winLo, cntExt;
  logic [FLAG_W-1:0] keepV, setV;

  always_comb begin
    cfg.winStart = ctrlWord[13:12];
    cfg.winEnd   = ctrlWord[9:8];
    cfg.preSel   = ctrlWord[7:4];
    cfg.period   = ctrlWord[1:0];

    // window bounds as multiples of a quarter period
    quarter = (Q_W'(reloadOf(cfg.period)) + Q_W'(1)) >> 2;
    hiMul   = Q_W'(cfg.winStart) + Q_W'(1);
    loMul   = Q_W'(2'd3 - cfg.winEnd);
    winHi   = quarter * hiMul - Q_W'(1);
    winLo   = quarter * loMul;
    cntExt  = Q_W'(cntVal);
    inWin   = (cntExt <= winHi) && (cntExt >= winLo);

    refWr   = wrEn && (wrAddr == ADR_REFRESH);
    wrZero  = refWr && (wrData[7:0] == 8'h00);
    wrAll   = refWr && (wrData[7:0] == 8'hFF);
    goodSeq = wrAll && armQ;
    badSeq  = wrAll && !armQ;
    winErr  = goodSeq && runQ && !inWin;

    cmd.startCnt  = goodSeq && !runQ;
    cmd.reloadReq = goodSeq && runQ && inWin;

    keepV = (wrEn && (wrAddr == ADR_STATUS)) ? (flags & wrData[FLAG_W-1:0]) : flags;
    setV  = '0;
    setV[FLG_UNDER] = underflow;
    setV[FLG_SEQ]   = badSeq;
    setV[FLG_WIN]   = winErr;

    irqOut = irqSelQ && (|flags);
    rstOut = !irqSelQ && (|flags);

    case (rdAddr)
      ADR_CTRL:   rdData = ctrlWord;
      ADR_STATUS: rdData = DATA_W'(flags);
      ADR_RSTCTL: rdData = {8'h00, irqSelQ, 7'b0};
      default:    rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      armQ     <= 1'b0;
      ctrlWord <= CTRL_RESET;
      irqSelQ  <= 1'b0;
      flags    <= '0;
    end else begin
      runQ  <= runQ | goodSeq;
      flags <= keepV | setV;
      if (refWr) armQ <= wrZero;
      if (wrEn && (wrAddr == ADR_CTRL) && !runQ) ctrlWord <= wrData & CTRL_MASK;
      if (wrEn && (wrAddr == ADR_RSTCTL)) irqSelQ <= wrData[7];
    end
  end
endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import winwdt_pkg::*;
#(
  parameter int RELOAD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstOut
);
  dpCmd_t            cmd;
  cfg_t              cfg;
  logic              runQ;
  logic [DATA_W-1:0] ctrlWord;
  logic [FLAG_W-1:0] flags;
  logic [CNT_W-1:0]  cntVal;
  logic              tickStb;
  logic              underflow;

  winwdt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .cntVal    (cntVal),
    .underflow (underflow),
    .cmd       (cmd),
    .cfg       (cfg),
    .runQ      (runQ),
    .ctrlWord  (ctrlWord),
    .flags     (flags),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .rstOut    (rstOut)
  );

  winwdt_dp #(.RELOAD_LAT(RELOAD_LAT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cntEn     (cntEn),
    .run       (runQ),
    .cmd       (cmd),
    .cfg       (cfg),
    .cntVal    (cntVal),
    .tickStb   (tickStb),
    .underflow (underflow)
  );
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk
  import winwdt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              runQ,
  input logic              tickStb,
  input logic              irqOut,
  input logic              rstOut,
  input logic [DATA_W-1:0] ctrlWord,
  input logic [CNT_W-1:0]  cntVal,
  input logic [FLAG_W-1:0] flags
);
  a_r12_ctrl_frozen: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> $stable(ctrlWord));

  a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> runQ);

  a_r2_idle_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !tickStb);

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !tickStb) |=> $stable(cntVal));

  a_r9_underflow_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLG_UNDER]) |-> ($past(cntVal) == '0));

  a_r11_one_output: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && rstOut));
endmodule

bind winwdt_top winwdt_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .runQ     (runQ),
  .tickStb  (tickStb),
  .irqOut   (irqOut),
  .rstOut   (rstOut),
  .ctrlWord (ctrlWord),
  .cntVal   (cntVal),
  .flags    (flags)
);

// File: tb/winwdt_top_tb_top.sv
module winwdt_top_tb_top;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = 3'h0;
  logic [15:0] wrData = 16'h0;
  logic [2:0]  rdAddr = 3'h4;
  logic [15:0] rdData;
  logic        irqOut, rstOut;

  int nChk = 0;
  int nErr = 0;
  int cyc = 0;
  bit done = 0;

  winwdt_top #(.RELOAD_LAT(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut), .rstOut(rstOut)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- reference model from the requirements ----------------
  function automatic int perN(input logic [1:0] c);
    case (c) 2'd0: return 1024; 2'd1: return 4096; 2'd2: return 8192; default: return 16384; endcase
  endfunction

  function automatic int divOf(input logic [3:0] s);
    case (s)
      4'd1: return 4;    4'd2: return 16;  4'd3: return 32;   4'd4: return 64;
      4'd5: return 256;  4'd6: return 512; 4'd7: return 2048; 4'd8: return 8192;
      default: return 1;
    endcase
  endfunction

  bit mRun, mArm, mIrq, mPend;
  logic [15:0] mCtrl;
  logic [2:0]  mStat, mKeep;
  int mCnt, mPre, mPendCnt, mN, mD, mQ, mHi, mLo;
  bit mTk, mLd, mUn, mRefW, mGood, mBad, mWin;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mArm = 0; mIrq = 0; mPend = 0; mCtrl = 16'h3303; mStat = 0;
      mCnt = 16383; mPre = 0; mPendCnt = 0;
    end else begin
      mN = perN(mCtrl[1:0]); mD = divOf(mCtrl[7:4]); mQ = mN / 4;
      mHi = mQ * (int'(mCtrl[13:12]) + 1) - 1;
      mLo = mQ * (3 - int'(mCtrl[9:8]));
      mTk = mRun && cntEn && ((mPre % mD) == mD - 1);
      mLd = mTk && mPend && (mPendCnt == LAT - 1);
      mUn = mTk && !mLd && (mCnt == 0);
      mRefW = wrEn && (wrAddr == 3'h0);
      mGood = mRefW && (wrData[7:0] == 8'hFF) && mArm;
      mBad  = mRefW && (wrData[7:0] == 8'hFF) && !mArm;
      mWin  = (mCnt <= mHi) && (mCnt >= mLo);
      mKeep = (wrEn && wrAddr == 3'h4) ? (mStat & wrData[2:0]) : mStat;
      mStat = mKeep | {mGood && mRun && !mWin, mBad, mUn};
      if (!mRun) mCnt = mN - 1;
      else if (mLd || mUn) mCnt = mN - 1;
      else if (mTk) mCnt = mCnt - 1;
      if (mGood && mRun && mWin) begin mPend = 1; mPendCnt = 0; end
      else if (mTk && mPend) begin
        if (mPendCnt == LAT - 1) mPend = 0; else mPendCnt = mPendCnt + 1;
      end
      if (mGood && !mRun) mPre = 0; else if (mRun && cntEn) mPre = mPre + 1;
      if (wrEn && wrAddr == 3'h2 && !mRun) mCtrl = wrData & 16'h33F3;
      if (wrEn && wrAddr == 3'h6) mIrq = wrData[7];
      if (mRefW) mArm = (wrData[7:0] == 8'h00);
      if (mGood) mRun = 1;
    end
  end

  function automatic logic [15:0] mRead(input logic [2:0] a);
    case (a)
      3'h2: return mCtrl;
      3'h4: return {13'b0, mStat};
      3'h6: return {8'h00, mIrq, 7'b0};
      default: return 16'h0;
    endcase
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; cntEn = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readChk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    rdAddr = a; #1;
    chk(tag, rdData, exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int t0;
    void'($urandom(32'd20240805));
    @(negedge clk);
    doReset();

    // R1 reset state
    readChk("R1 ctrl reset", 3'h2, 16'h3303);
    readChk("R1 status reset", 3'h4, 16'h0000);
    readChk("R1 rstctl reset", 3'h6, 16'h0000);
    chk("R1 irqOut low", irqOut, 0);
    chk("R1 rstOut low", rstOut, 0);

    // R2 idle until first valid pair
    repeat (2000) @(negedge clk);
    readChk("R2 idle no underflow", 3'h4, 16'h0000);

    // R12 mask before start
    wr(3'h2, 16'hFFFF);
    readChk("R12 ctrl mask", 3'h2, 16'h33F3);
    wr(3'h2, 16'h3300);
    readChk("R12 ctrl write before start", 3'h2, 16'h3300);

    // R8 stray 0xFF
    wr(3'h0, 16'h00FF);
    readChk("R8 stray FF flag", 3'h4, 16'h0002);
    repeat (1100) @(negedge clk);
    readChk("R8 stray FF does not start", 3'h4, 16'h0002);
    wr(3'h4, 16'h0000);
    readChk("R10 clear by zero", 3'h4, 16'h0000);

    // R3 period 1024 at divide-by-1
    wr(3'h0, 16'h0000); wr(3'h0, 16'h00FF);
    t0 = cyc;
    waitUntil(t0 + 1023);
    readChk("R3 no underflow before N", 3'h4, 16'h0000);
    waitUntil(t0 + 1024);
    readChk("R3 underflow at N", 3'h4, 16'h0001);
    chk("R11 reset response", rstOut, 1);
    chk("R11 no irq in reset mode", irqOut, 0);
    wr(3'h6, 16'h0080);
    chk("R11 irq response", irqOut, 1);
    chk("R11 rstOut low in irq mode", rstOut, 0);
    readChk("R11 rstctl readback", 3'h6, 16'h0080);
    wr(3'h2, 16'h0000);
    readChk("R12 ctrl frozen after start", 3'h2, 16'h3300);
    wr(3'h4, 16'h0000);
    readChk("R10 status cleared", 3'h4, 16'h0000);
    waitUntil(t0 + 2047);
    readChk("R9 no second underflow early", 3'h4, 16'h0000);
    waitUntil(t0 + 2048);
    readChk("R9 repeated underflow", 3'h4, 16'h0001);
    chk("R9 irq after repeat", irqOut, 1);

    // R5 R6 R7 window: upper 50% (511), lower 25% (256)
    doReset();
    wr(3'h2, 16'h1200);
    wr(3'h0, 16'h0000); wr(3'h0, 16'h00FF);
    t0 = cyc;
    waitUntil(t0 + 98);
    wr(3'h0, 16'h0000); wr(3'h0, 16'h00FF);     // count 924: too early
    readChk("R7 early refresh flagged", 3'h4, 16'h0004);
    waitUntil(t0 + 622);
    wr(3'h0, 16'h0000); wr(3'h0, 16'h00FF);     // count 400: inside
    readChk("R5 in-window refresh accepted", 3'h4, 16'h0004);
    waitUntil(t0 + 1024);
    readChk("R6 reload prevents first underflow", 3'h4, 16'h0004);
    waitUntil(t0 + 1649);
    readChk("R6 no underflow before reload+N", 3'h4, 16'h0004);
    waitUntil(t0 + 1650);
    readChk("R6 underflow at reload+N", 3'h4, 16'h0005);

    // R4 prescaler divide-by-4 with a 500-cycle pause of cntEn
    doReset();
    wr(3'h2, 16'h3310);
    wr(3'h0, 16'h0000); wr(3'h0, 16'h00FF);
    t0 = cyc;
    cntEn = 1'b0;
    waitUntil(t0 + 500);
    cntEn = 1'b1;
    waitUntil(t0 + 4595);
    readChk("R4 no underflow before 4096 pulses", 3'h4, 16'h0000);
    waitUntil(t0 + 4596);
    readChk("R4 underflow after 4096 pulses", 3'h4, 16'h0001);

    // random phase against the model (R3 R5 R6 R7 R8 R9 R10 R11 R12)
    doReset();
    for (int i = 0; i < 20000; i++) begin
      chk("R5 R7 R8 R9 R10 R12 readback", rdData, mRead(rdAddr));
      chk("R11 irqOut", irqOut, mIrq && (mStat != 0));
      chk("R11 rstOut", rstOut, !mIrq && (mStat != 0));
      begin
        int r = int'($urandom % 100);
        int v = int'($urandom % 10);
        wrEn = 1'b0;
        cntEn = ($urandom % 4) != 0;
        rdAddr = 3'(($urandom % 4) * 2);
        if (r < 8) begin
          wrEn = 1'b1; wrAddr = 3'h0;
          wrData = (v < 4) ? 16'h0000 : (v < 8) ? 16'h00FF : 16'($urandom % 256);
        end else if (r < 9) begin
          wrEn = 1'b1; wrAddr = 3'h4; wrData = 16'($urandom);
        end else if (r < 10) begin
          wrEn = 1'b1; wrAddr = 3'h6; wrData = 16'($urandom);
        end else if (r < 11) begin
          wrEn = 1'b1; wrAddr = 3'h2; wrData = 16'($urandom) & 16'h3311;
        end
      end
      @(negedge clk);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule